// File: doc/BRIEF.md
# Coprocessor Task Dispatcher

This block decides which of eight tasks a small coprocessor runs next. Each task can be requested by a rising edge on a selectable peripheral interrupt line, by a protected force write from the host, or by a lightweight acknowledge-style bitmask write that is honoured only while a control enable is set. Requests collect in a pending register. A per-task enable mask gates which pending tasks are eligible to run.

While the coprocessor is idle, the dispatcher launches the lowest-numbered task that is both pending and enabled. Task 1 outranks task 8. On launch it marks the task as running, drops its pending bit, and hands the task's 16-bit start address to the core with a one-cycle start strobe. It then waits for the core's stop strobe. On stop it clears the running bit and pulses that task's completion interrupt. Tasks never nest, and the next eligible task launches automatically.

A trigger that arrives while the same task is still pending sets a sticky overflow bit. The host clears pending and overflow bits by writing ones.

Top module: `task_dispatch`

## Requirements
- R1: Among tasks that are pending and enabled, the one with the lowest index is launched (bit 0 = task 1 = highest priority, bit 7 = task 8).
- R2: While a task runs, no other task is launched, whatever its priority; pending requests wait.
- R3: With no task running, a pending and enabled task is launched at the next clock edge. At that edge its running bit is set, its pending bit is cleared, `core_start` pulses for one cycle and `core_pc` carries that task's 16-bit vector.
- R4: A `core_stop` while a task runs clears the running bit and pulses that task's `done_irq` bit for exactly one cycle. A `core_stop` while idle has no effect.
- R5: On the clock edge after the completion edge, the next pending and enabled task launches without host action.
- R6: Each task has a select field. Value 0 means no source. Value k (1..NSRC) makes a rising edge on `periph_irq[k-1]` set that task's pending bit. A held-high level does not re-trigger.
- R7: A peripheral rising edge for a task whose pending bit is already set also sets its overflow bit. The overflow bit stays set until the host clears it through `ovf_clr_we`.
- R8: A force write sets the pending bits of its mask only when `prot_open` is high. Otherwise it is ignored.
- R9: An acknowledge write sets the pending bits of its mask (bit n-1 flags task n, so 0x03 flags tasks 1 and 2) only when `ack_en` is high.
- R10: A flag-clear write of 1 clears that pending bit, which cancels a task that has not started. A peripheral trigger landing on the same task in the same cycle wins over the clear.
- R11: Clearing a task's enable bit does not affect that task while it runs. A pending but disabled task stays pending and is not launched.
- R12: After reset, the pending, overflow, running and completion bits are zero and `core_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_irq | input | NSRC | Peripheral interrupt lines |
| src_sel | input | NTASK*SEL_W | Per-task source select, task t in bits [t*SEL_W +: SEL_W] |
| task_vec | input | NTASK*16 | Per-task start address, task t in bits [t*16 +: 16] |
| task_en | input | NTASK | Per-task enable mask |
| prot_open | input | 1 | Write-protection lifted for force writes |
| force_we | input | 1 | Force write strobe |
| force_mask | input | NTASK | Tasks to flag on force write |
| ack_en | input | 1 | Control bit enabling acknowledge writes |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_mask | input | NTASK | Tasks to flag on acknowledge write |
| flag_clr_we | input | 1 | Pending-clear strobe |
| flag_clr_mask | input | NTASK | Pending bits to clear |
| ovf_clr_we | input | 1 | Overflow-clear strobe |
| ovf_clr_mask | input | NTASK | Overflow bits to clear |
| core_stop | input | 1 | End-of-task strobe from the core |
| core_start | output | 1 | One-cycle launch strobe to the core |
| core_pc | output | 16 | Start address of the launched task |
| pend_flags | output | NTASK | Pending register |
| ovf_flags | output | NTASK | Overflow register |
| run_flags | output | NTASK | Running-task register (one-hot or zero) |
| done_irq | output | NTASK | Per-task completion pulses |

## Verification
The bench forces every non-empty request mask and follows the whole dispatch chain. A wrong priority encoder would launch tasks out of ascending order. A chaining bug would stall after the first completion or launch two tasks at once. A sweep of every task, select value and source line catches an off-by-one in the select decode, which would answer the wrong line or treat value 0 as a live source. A design that nested tasks or reacted to the enable mask mid-task would drop or replace the running bit. A clear winning over a same-cycle trigger would silently lose a request. Protected and acknowledge writes are driven with their gates both closed and open, so a missing gate shows up as spurious pending bits.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int unsigned PC_W = 16;

  function automatic int unsigned sel_width(int unsigned nsrc);
    return $clog2(nsrc + 1);
  endfunction
endpackage

// File: rtl/dsp_trig.sv
module dsp_trig #(
  parameter int unsigned NTASK = 8,
  parameter int unsigned NSRC  = 8,
  parameter int unsigned SEL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        src,
  input  logic [NTASK*SEL_W-1:0] sel_flat,
  output logic [NTASK-1:0]       trig
);
  logic [NSRC-1:0] prev_q, prev_d, rise;

  always_comb begin
    prev_d = src;
    rise   = src & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar t = 0; t < NTASK; t++) begin : g_task
    logic [SEL_W-1:0] s;
    assign s = sel_flat[t*SEL_W +: SEL_W];
    always_comb begin
      trig[t] = 1'b0;
      for (int j = 0; j < NSRC; j++)
        if (s == SEL_W'(j + 1)) trig[t] = rise[j];
    end
  end
endmodule

// File: rtl/dsp_prio.sv
module dsp_prio #(
  parameter int unsigned NTASK = 8
) (
  input  logic [NTASK-1:0] req,
  output logic [NTASK-1:0] pick
);
  always_comb pick = req & (~req + 1'b1);
endmodule

// File: rtl/task_dispatch.sv
module task_dispatch #(
  parameter int unsigned NTASK = 8,
  parameter int unsigned NSRC  = 8,
  localparam int unsigned SEL_W = dsp_pkg::sel_width(NSRC),
  localparam int unsigned PC_W  = dsp_pkg::PC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        periph_irq,
  input  logic [NTASK*SEL_W-1:0] src_sel,
  input  logic [NTASK*PC_W-1:0]  task_vec,
  input  logic [NTASK-1:0]       task_en,
  input  logic                   prot_open,
  input  logic                   force_we,
  input  logic [NTASK-1:0]       force_mask,
  input  logic                   ack_en,
  input  logic                   ack_we,
  input  logic [NTASK-1:0]       ack_mask,
  input  logic                   flag_clr_we,
  input  logic [NTASK-1:0]       flag_clr_mask,
  input  logic                   ovf_clr_we,
  input  logic [NTASK-1:0]       ovf_clr_mask,
  input  logic                   core_stop,
  output logic                   core_start,
  output logic [PC_W-1:0]        core_pc,
  output logic [NTASK-1:0]       pend_flags,
  output logic [NTASK-1:0]       ovf_flags,
  output logic [NTASK-1:0]       run_flags,
  output logic [NTASK-1:0]       done_irq
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic [NTASK-1:0] trig, pick, ready;
  logic [NTASK-1:0] pend_q, pend_d, ovf_q, ovf_d, run_q, run_d, done_q, done_d;
  logic [NTASK-1:0] sw_set, pclr, oclr, launch_vec;
  logic             start_q, start_d, idle, launch, finish;
  logic [PC_W-1:0]  pc_q, pc_d;

  dsp_trig #(.NTASK(NTASK), .NSRC(NSRC), .SEL_W(SEL_W)) u_trig (
    .clk(clk), .rst_n(rst_core_n), .src(periph_irq), .sel_flat(src_sel), .trig(trig)
  );

  dsp_prio #(.NTASK(NTASK)) u_prio (.req(ready), .pick(pick));

  always_comb begin
    sw_set     = ((force_we && prot_open) ? force_mask : '0)
               | ((ack_we && ack_en) ? ack_mask : '0);
    pclr       = flag_clr_we ? flag_clr_mask : '0;
    oclr       = ovf_clr_we ? ovf_clr_mask : '0;
    ready      = pend_q & task_en;
    idle       = (run_q == '0);
    launch     = idle && (ready != '0);
    finish     = !idle && core_stop;
    launch_vec = launch ? pick : '0;

    pend_d  = (pend_q & ~pclr & ~launch_vec) | trig | sw_set;
    ovf_d   = (ovf_q & ~oclr) | (trig & pend_q);
    run_d   = finish ? '0 : (launch ? pick : run_q);
    done_d  = finish ? run_q : '0;
    start_d = launch;
    pc_d    = pc_q;
    for (int i = 0; i < NTASK; i++)
      if (pick[i]) pc_d = task_vec[i*PC_W +: PC_W];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pend_q  <= '0;
      ovf_q   <= '0;
      run_q   <= '0;
      done_q  <= '0;
      start_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      ovf_q   <= ovf_d;
      run_q   <= run_d;
      done_q  <= done_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  pc_q <= '0;
    else if (launch)  pc_q <= pc_d;
  end

  assign core_start = start_q;
  assign core_pc    = pc_q;
  assign pend_flags = pend_q;
  assign ovf_flags  = ovf_q;
  assign run_flags  = run_q;
  assign done_irq   = done_q;

  // R2: at most one task marked running
  assert_single_run_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(run_q));

  // R2: a running task is only removed by a stop
  assert_no_preempt_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_q != '0 && !core_stop) |=> (run_q == $past(run_q)));

  // R1 R3: a launched task was ready and nothing of higher rank was
  assert_launch_prio_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    core_start |-> (((run_q & $past(pend_q & task_en)) == run_q) && (run_q != '0)
                   && (($past(pend_q & task_en) & (run_q - 1'b1)) == '0)));

  // R4: stop clears running and signals that task
  assert_stop_done_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_q != '0 && core_stop) |=> (run_q == '0 && done_q == $past(run_q)));

  // R7: overflow bits only drop on a host clear
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ovf_q != '0) |=> ((($past(ovf_q) & ~$past(oclr)) & ~ovf_q) == '0));
endmodule

// File: tb/sim_task_dispatch.sv
module sim_task_dispatch;
  localparam int NT = 8;
  localparam int NS = 8;
  localparam int SW = dsp_pkg::sel_width(NS);

  logic clk = 1'b0;
  always #4ns clk = ~clk;

  logic rst_n;
  logic [NS-1:0]    periph_irq;
  logic [NT*SW-1:0] src_sel;
  logic [NT*16-1:0] task_vec;
  logic [NT-1:0]    task_en, force_mask, ack_mask, flag_clr_mask, ovf_clr_mask;
  logic prot_open, force_we, ack_en, ack_we, flag_clr_we, ovf_clr_we, core_stop;
  logic core_start;
  logic [15:0] core_pc;
  logic [NT-1:0] pend_flags, ovf_flags, run_flags, done_irq;

  task_dispatch #(.NTASK(NT), .NSRC(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .periph_irq(periph_irq), .src_sel(src_sel),
    .task_vec(task_vec), .task_en(task_en), .prot_open(prot_open),
    .force_we(force_we), .force_mask(force_mask), .ack_en(ack_en), .ack_we(ack_we),
    .ack_mask(ack_mask), .flag_clr_we(flag_clr_we), .flag_clr_mask(flag_clr_mask),
    .ovf_clr_we(ovf_clr_we), .ovf_clr_mask(ovf_clr_mask), .core_stop(core_stop),
    .core_start(core_start), .core_pc(core_pc), .pend_flags(pend_flags),
    .ovf_flags(ovf_flags), .run_flags(run_flags), .done_irq(done_irq)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  function automatic logic [15:0] vec_of(int i);
    return 16'h1000 + 16'(i) * 16'h0111;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_pend();
    flag_clr_we = 1'b1; flag_clr_mask = '1;
    tick();
    flag_clr_we = 1'b0; flag_clr_mask = '0;
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; periph_irq = '0; src_sel = '0; task_en = '0;
    force_mask = '0; ack_mask = '0; flag_clr_mask = '0; ovf_clr_mask = '0;
    prot_open = 0; force_we = 0; ack_en = 0; ack_we = 0;
    flag_clr_we = 0; ovf_clr_we = 0; core_stop = 0;
    for (int i = 0; i < NT; i++) task_vec[i*16 +: 16] = vec_of(i);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R12 reset state
    check("R12 pend", pend_flags, 0);
    check("R12 ovf", ovf_flags, 0);
    check("R12 run", run_flags, 0);
    check("R12 done", done_irq, 0);
    check("R12 start", core_start, 0);

    // R8 protected force
    force_we = 1; force_mask = 8'hFF; prot_open = 0;
    tick();
    force_we = 0;
    check("R8 force blocked", pend_flags, 0);
    force_we = 1; force_mask = 8'h81; prot_open = 1;
    tick();
    force_we = 0; prot_open = 0;
    check("R8 force open", pend_flags, 8'h81);
    check("R11 disabled stays idle", run_flags, 0);
    clear_pend();
    check("R10 clear all", pend_flags, 0);

    // R9 acknowledge write
    ack_we = 1; ack_mask = 8'h03; ack_en = 0;
    tick();
    check("R9 ack blocked", pend_flags, 0);
    ack_en = 1;
    tick();
    ack_we = 0; ack_en = 0;
    check("R9 ack mask 3", pend_flags, 8'h03);
    tick();
    check("R11 pending disabled kept", pend_flags, 8'h03);
    check("R11 pending disabled no run", run_flags, 0);
    flag_clr_we = 1; flag_clr_mask = 8'h01;
    tick();
    flag_clr_we = 0;
    check("R10 cancel task1", pend_flags, 8'h02);
    clear_pend();

    // R6 select/source sweep
    for (int t = 0; t < NT; t++)
      for (int s = 0; s <= NS; s++)
        for (int j = 0; j < NS; j++) begin
          src_sel = '0;
          src_sel[t*SW +: SW] = SW'(s);
          periph_irq = '0; periph_irq[j] = 1'b1;
          tick();
          check($sformatf("R6 t%0d s%0d j%0d", t, s, j), pend_flags,
                (s == j + 1) ? (32'd1 << t) : 32'd0);
          periph_irq = '0;
          clear_pend();
        end
    check("R7 single edges no ovf", ovf_flags, 0);

    // R7 overflow, level, sticky, clear
    src_sel = '0; src_sel[2*SW +: SW] = SW'(5);
    periph_irq[4] = 1; tick();
    check("R6 edge sets", pend_flags, 8'h04);
    tick();
    check("R6 level no retrigger", ovf_flags, 0);
    periph_irq[4] = 0; tick();
    periph_irq[4] = 1; tick();
    check("R7 ovf set", ovf_flags, 8'h04);
    periph_irq[4] = 0; repeat (3) tick();
    check("R7 ovf sticky", ovf_flags, 8'h04);
    periph_irq[4] = 1; flag_clr_we = 1; flag_clr_mask = 8'h04;
    tick();
    flag_clr_we = 0; periph_irq[4] = 0;
    check("R10 trigger beats clear", pend_flags, 8'h04);
    ovf_clr_we = 1; ovf_clr_mask = 8'h04;
    tick();
    ovf_clr_we = 0;
    check("R7 ovf cleared", ovf_flags, 0);
    clear_pend();
    src_sel = '0;

    // R1 R3 R4 R5 exhaustive masks
    task_en = '1;
    for (int m = 1; m < 256; m++) begin
      logic [7:0] rem, low;
      rem = 8'(m);
      force_we = 1; prot_open = 1; force_mask = 8'(m);
      tick();
      force_we = 0; prot_open = 0;
      while (rem != 0) begin
        int idx;
        tick();
        low = rem & (~rem + 8'd1);
        rem = rem ^ low;
        idx = 0;
        for (int b = 0; b < NT; b++) if (low[b]) idx = b;
        check($sformatf("R1 order m%0h", m), run_flags, low);
        check("R3 start pulse", core_start, 1);
        check("R3 pc", core_pc, vec_of(idx));
        check("R3 pend cleared", pend_flags, rem);
        core_stop = 1; tick(); core_stop = 0;
        check("R4 run cleared", run_flags, 0);
        check("R4 done", done_irq, low);
        check("R5 no start yet", core_start, 0);
      end
      tick();
      check("R4 done one cycle", done_irq, 0);
      check("R5 chain ends idle", run_flags, 0);
    end

    // R2 no preemption, R11 enable while running
    force_we = 1; prot_open = 1; force_mask = 8'h10;
    tick(); force_we = 0;
    tick();
    check("R3 task5 runs", run_flags, 8'h10);
    tick();
    check("R3 start one cycle", core_start, 0);
    force_we = 1; force_mask = 8'h01;
    tick(); force_we = 0; prot_open = 0;
    tick();
    check("R2 no preempt run", run_flags, 8'h10);
    check("R2 high prio waits", pend_flags, 8'h01);
    task_en = '0; tick();
    check("R11 disable keeps running", run_flags, 8'h10);
    task_en = '1;
    core_stop = 1; tick(); core_stop = 0;
    check("R4 done task5", done_irq, 8'h10);
    tick();
    check("R5 auto next", run_flags, 8'h01);
    check("R5 pc task1", core_pc, vec_of(0));
    core_stop = 1; tick(); core_stop = 0;
    tick();
    core_stop = 1; tick(); core_stop = 0;
    check("R4 idle stop ignored", done_irq, 0);
    check("R4 idle stays idle", run_flags, 0);

    // R3 enable gating
    task_en = 8'h0C;
    force_we = 1; prot_open = 1; force_mask = 8'h05;
    tick(); force_we = 0; prot_open = 0;
    tick();
    check("R3 enabled only", run_flags, 8'h04);
    core_stop = 1; tick(); core_stop = 0;
    tick();
    check("R11 disabled not launched", run_flags, 0);
    check("R11 disabled pending", pend_flags, 8'h01);
    clear_pend();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule